// File: doc/BRIEF.md
# VGA Test Pattern Generator

This block drives a VGA monitor at 640x480, 60 Hz, from a pixel-rate clock supplied by the surrounding chip. It runs the horizontal and vertical raster counters, produces active-low horizontal and vertical sync, and outputs 4-bit red, green and blue levels for a resistor-ladder DAC. The picture is a test card chosen by a 3-bit selector wired to board switches or push-buttons.

The selector picks a blank screen, a solid red, green or blue field, a 32-pixel black/white checkerboard, or eight vertical colour bars. The selector inputs are asynchronous. They pass through a two-stage synchronizer, and the synchronized value is adopted only at the frame boundary, so a frame never shows two patterns. Every output is registered.

Top module: `vga_testcard`

## Requirements
- R1: While `rst_n` is low, `hsync_n` and `vsync_n` are high and all colour outputs are zero; the adopted pattern after reset is code 000.
- R2: After the k-th rising clock edge following reset release, the outputs show horizontal position (k-1) mod 800. A line is 800 clocks long, and `hsync_n` is low for exactly the 96 positions 656 to 751.
- R3: A frame has 525 lines, and `vsync_n` is low for the whole of lines 490 and 491.
- R4: Pattern codes 000, 110 and 111 give zero on all colour channels.
- R5: Codes 001, 010 and 011 give a solid field with 4'hF on red, green or blue respectively and zero on the other two channels.
- R6: Code 100 gives a checkerboard of 32x32 squares: white (all channels 4'hF) when bit 5 of x XOR bit 5 of y is 0, and black otherwise.
- R7: Code 101 gives eight bands, each 80 pixels wide, from left to right: white, yellow, cyan, green, magenta, red, blue, black. Each channel is either 4'hF or 0.
- R8: Outside the visible area (x >= 640 or y >= 480) all colour outputs are zero, whatever the code.
- R9: `sel_in` is sampled through two flip-flops. The synchronized value is adopted only on the clock that ends the last position (799, 524) of a frame. A change during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_in | input | 3 | Pattern code from switches, asynchronous |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 4 | Red level |
| green | output | 4 | Green level |
| blue | output | 4 | Blue level |

## Verification
On every cycle the assertions check the length of the horizontal sync pulse, where the vertical sync starts within a line, that colour is zero during blanking and for the disabled codes, the solid red field, and that the adopted pattern changes only at a frame boundary. The colour of each checkerboard square and bar, the exact cycle in which sync switches, and the pipeline delay of a selector change can only be shown by the bench. Its raster model runs a reduced-size configuration through every code over several frames, with a disturbance in the middle of each frame. A second instance at full size checks the 800-clock line timing.

// File: rtl/vga_testcard.sv
module vga_testcard #(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int SQ_LOG2 = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel_in,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic [3:0] red,
  output logic [3:0] green,
  output logic [3:0] blue
);
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int BAR_W = H_VIS / 8;
  localparam int BW    = $clog2(BAR_W);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [2:0]    sync1, sync2, sel_act;
  logic [BW-1:0] bar_cnt;
  logic [2:0]    bar_idx;
  logic [11:0]   pix;
  logic          h_end, frame_end, visible, hs_on, vs_on;

  assign h_end     = hcnt == HW'(H_TOT - 1);
  assign frame_end = h_end && (vcnt == VW'(V_TOT - 1));
  assign visible   = (hcnt < HW'(H_VIS)) && (vcnt < VW'(V_VIS));
  assign hs_on     = (hcnt >= HW'(H_VIS + H_FP)) && (hcnt < HW'(H_VIS + H_FP + H_SYNC));
  assign vs_on     = (vcnt >= VW'(V_VIS + V_FP)) && (vcnt < VW'(V_VIS + V_FP + V_SYNC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      sel_act <= '0;
    end else begin
      sync1 <= sel_in;
      sync2 <= sync1;
      if (frame_end) sel_act <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_cnt <= '0;
      bar_idx <= '0;
    end else if (h_end) begin
      bar_cnt <= '0;
      bar_idx <= '0;
    end else if (bar_cnt == BW'(BAR_W - 1)) begin
      bar_cnt <= '0;
      bar_idx <= bar_idx + 1'b1;
    end else begin
      bar_cnt <= bar_cnt + 1'b1;
    end
  end

  always_comb begin
    pix = '0;
    if (visible) begin
      case (sel_act)
        3'd1:    pix = 12'hF00;
        3'd2:    pix = 12'h0F0;
        3'd3:    pix = 12'h00F;
        3'd4:    pix = (hcnt[SQ_LOG2] ^ vcnt[SQ_LOG2]) ? 12'h000 : 12'hFFF;
        3'd5:    pix = {{4{~bar_idx[1]}}, {4{~bar_idx[2]}}, {4{~bar_idx[0]}}};
        default: pix = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      {red, green, blue} <= '0;
    end else begin
      hsync_n <= ~hs_on;
      vsync_n <= ~vs_on;
      {red, green, blue} <= pix;
    end
  end
endmodule

// File: rtl/vga_testcard_chk.sv
module vga_testcard_chk #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP,
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP,
  localparam int HW    = $clog2(H_TOT),
  localparam int VW    = $clog2(V_TOT)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hcnt,
  input logic [VW-1:0] vcnt,
  input logic [2:0]    sel_act,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic [3:0]    red,
  input logic [3:0]    green,
  input logic [3:0]    blue
);
  logic        armed;
  logic [15:0] low_len;
  logic        at_end, in_view;

  assign at_end  = (hcnt == HW'(H_TOT - 1)) && (vcnt == VW'(V_TOT - 1));
  assign in_view = (hcnt < HW'(H_VIS)) && (vcnt < VW'(V_VIS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      low_len <= '0;
    end else begin
      armed   <= 1'b1;
      low_len <= hsync_n ? 16'd0 : low_len + 16'd1;
    end
  end

  assert_hsync_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && hsync_n && $past(!hsync_n)) |-> (low_len == 16'(H_SYNC)));

  assert_vsync_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(vsync_n)) |-> ($past(hcnt) == '0));

  assert_blank_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_view)) |-> ({red, green, blue} == 12'h000));

  assert_off_codes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ($past(sel_act) == 3'd0 || $past(sel_act) >= 3'd6)) |-> ({red, green, blue} == 12'h000));

  assert_solid_red_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_view) && $past(sel_act) == 3'd1) |-> ({red, green, blue} == 12'hF00));

  assert_sel_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(at_end)) |-> $stable(sel_act));
endmodule

bind vga_testcard vga_testcard_chk #(
  .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
  .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .sel_act(sel_act),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .green(green), .blue(blue)
);

// File: tb/vga_testcard_tb.sv
module vga_testcard_tb;
  localparam int SH = 160, SHF = 8, SHS = 16, SHB = 8;
  localparam int SV = 80,  SVF = 2, SVS = 2,  SVB = 4;
  localparam int SHT = SH + SHF + SHS + SHB;
  localparam int SVT = SV + SVF + SVS + SVB;
  localparam int FR  = SHT * SVT;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] sel_in;
  logic hs, vs, hs_f, vs_f;
  logic [3:0] r, g, b, r_f, g_f, b_f;

  always #10 clk = ~clk;

  vga_testcard #(.H_VIS(SH), .H_FP(SHF), .H_SYNC(SHS), .H_BP(SHB),
                 .V_VIS(SV), .V_FP(SVF), .V_SYNC(SVS), .V_BP(SVB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .hsync_n(hs), .vsync_n(vs),
    .red(r), .green(g), .blue(b));

  vga_testcard u_dut_full (
    .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .hsync_n(hs_f), .vsync_n(vs_f),
    .red(r_f), .green(g_f), .blue(b_f));

  int tests = 0, fails = 0;
  bit done = 0;

  int mh, mv, m1, m2, ma, fh, fv;
  logic ehs, evs, fhs, fvs;
  logic [11:0] ergb;
  string etag;

  function automatic logic [11:0] pix(int s, int x, int y, int bw);
    logic [11:0] bars [8] = '{12'hFFF, 12'hFF0, 12'h0FF, 12'h0F0, 12'hF0F, 12'hF00, 12'h00F, 12'h000};
    case (s)
      1: return 12'hF00;
      2: return 12'h0F0;
      3: return 12'h00F;
      4: return ((((x >> 5) ^ (y >> 5)) & 1) != 0) ? 12'h000 : 12'hFFF;
      5: return bars[x / bw];
      default: return 12'h000;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      1, 2, 3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0; m1 = 0; m2 = 0; ma = 0; fh = 0; fv = 0;
      ehs = 1; evs = 1; ergb = 0; fhs = 1; fvs = 1; etag = "R1";
    end else begin
      ehs  = !(mh >= SH + SHF && mh < SH + SHF + SHS);
      evs  = !(mv >= SV + SVF && mv < SV + SVF + SVS);
      ergb = (mh < SH && mv < SV) ? pix(ma, mh, mv, SH / 8) : 12'h000;
      etag = (mh < SH && mv < SV) ? tag_of(ma) : "R8";
      if (mh == SHT - 1 && mv == SVT - 1) ma = m2;
      m2 = m1;
      m1 = int'(sel_in);
      mh++;
      if (mh == SHT) begin mh = 0; mv++; if (mv == SVT) mv = 0; end
      fhs = !(fh >= 656 && fh < 752);
      fvs = !(fv >= 490 && fv < 492);
      fh++;
      if (fh == 800) begin fh = 0; fv++; if (fv == 525) fv = 0; end
    end
  end

  task automatic chk(bit ok, string req, logic [11:0] act, logic [11:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done && rst_n) begin
      chk(hs == ehs, "R2", 12'(hs), 12'(ehs));
      chk(vs == evs, "R3", 12'(vs), 12'(evs));
      chk({r, g, b} == ergb, etag, {r, g, b}, ergb);
      chk(hs_f == fhs, "R2", 12'(hs_f), 12'(fhs));
      chk(vs_f == fvs, "R3", 12'(vs_f), 12'(fvs));
      chk({r_f, g_f, b_f} == 12'h000, "R8", {r_f, g_f, b_f}, 12'h000);
    end
  end

  initial begin
    logic [2:0] codes [8] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd0};
    rst_n = 1'b0;
    sel_in = 3'd0;
    repeat (5) @(negedge clk);
    chk(hs && vs && {r, g, b} == 12'h000, "R1", {hs, vs, 2'b00, r, g}, 12'hC00);
    chk(hs_f && vs_f && {r_f, g_f, b_f} == 12'h000, "R1", {r_f, g_f, b_f}, 12'h000);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      repeat (2 * SHT) @(negedge clk);
      sel_in = codes[k];
      repeat (FR / 2) @(negedge clk);
      sel_in = codes[k] ^ 3'b011; // R9: mid-frame disturbance must not show
      repeat (300) @(negedge clk);
      sel_in = codes[k];
      repeat (FR - FR / 2 - 300 - 2 * SHT) @(negedge clk);
    end
    repeat (FR) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    done = 1;
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule